// File: doc/BRIEF.md
# SoC Memory and Bus Error Monitor

This block gathers error events raised outside the processor core and turns them into one external error request for the core. Two sources feed it: the memory ECC path, which reports a corrected single-bit upset or a detected double-bit upset together with the faulting address and the raw encoded word, and the bus master, which pulses a strobe when an access timed out. Each accepted event sets a sticky status bit. For memory events the block also latches the details that trap software needs: the data address, where that word's check code lives, the encoded word as read, and the address of the upset seen before.

Memory error reporting starts disabled, because freshly powered memory holds garbage that would raise a flood of false upsets. Software zero-fills the memory and then sets the enable. The enable is kept as three voted copies that refresh each other every cycle, so a single flipped copy heals itself. A stuck cell would otherwise trap forever, so the block remembers the two most recent upset addresses and silently drops a new memory error that matches both.

Top module: `soc_err_monitor`

## Requirements
- R1: After reset every register reads zero, the history holds no valid address and `ext_err` is low.
- R2: Status bit 0 flags a bus timeout, bit 1 a single-bit memory upset, bit 2 a double-bit memory upset; a bit sets on the clock edge that samples its event and `ext_err` is high whenever any status bit is set.
- R3: Writing the status register (offset 0) clears each bit written as 1; if an event sets a bit in the same cycle as a clear, the bit stays set.
- R4: While the voted enable is 0, memory errors change no status bit, no captured field and no history entry.
- R5: A bus timeout sets status bit 0 whatever the enable holds.
- R6: On an accepted memory error the block captures the data address (offset 2), the check-code address, equal to the data address divided by 4 plus three quarters of 2^ADDR_W (offset 3), encoded bits 31:0 (offset 4) and the encoded bits above 31, zero extended (offset 5).
- R7: Offset 6 captures the newest history address at the moment of an accepted error, or zero if the history held none; the accepted address then becomes the newest and the older entry is discarded.
- R8: A memory error whose address equals both valid history entries is dropped: no status bit, no capture, history unchanged.
- R9: Writing offset 1 loads bit 0 of the write data into all three enable copies; reading offset 1 returns the voted value in bit 0.
- R10: The first two memory errors after reset are accepted even if their addresses are equal (and equal to zero).
- R11: `mem_dbl` selects the status bit of a memory error: 1 gives bit 2, 0 gives bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_err | input | 1 | Memory ECC path reports an upset this cycle |
| mem_dbl | input | 1 | Upset is double-bit (uncorrectable) |
| mem_addr | input | ADDR_W | Byte address of the faulting data word |
| mem_enc | input | ENC_W | Encoded word as read, before correction |
| bus_timeout | input | 1 | Bus master access timed out this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ext_err | output | 1 | External error request to the core |

## Verification
The bench builds the block with ADDR_W = 6 and ENC_W = 39, so the data region is 48 bytes and the check-code region starts at 48. That small space lets the bench walk every data address with alternating single and double upsets, computing the check address, the split encoded word and the expected previous address arithmetically. The short history then makes stuck-bit drops, the unchanged history after a drop and the unfiltered first errors after reset easy to provoke on purpose.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int NUM_SRC    = 3;
    localparam int ST_TIMEOUT = 0;
    localparam int ST_SINGLE  = 1;
    localparam int ST_DOUBLE  = 2;

    typedef enum logic [2:0] {
        REG_STATUS     = 3'd0,
        REG_ENABLE     = 3'd1,
        REG_FAULT_ADDR = 3'd2,
        REG_CHECK_ADDR = 3'd3,
        REG_WORD_LO    = 3'd4,
        REG_WORD_HI    = 3'd5,
        REG_PREV_ADDR  = 3'd6
    } sem_reg_e;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/sem_tmr_enable.sv
module sem_tmr_enable
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    output logic vote
);
    logic [2:0] copy_q;

    assign vote = maj3(copy_q);

    always_ff @(posedge clk) begin
        if (rst)
            copy_q <= 3'b000;
        else if (wr_en)
            copy_q <= {3{wr_val}};
        else
            copy_q <= {3{vote}};
    end
endmodule

// File: rtl/sem_upset_filter.sv
module sem_upset_filter #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              accept,
    output logic              drop,
    output logic [ADDR_W-1:0] newest
);
    logic [ADDR_W-1:0] hist_addr [DEPTH];
    logic [DEPTH-1:0]  hist_vld;
    logic              all_match;

    always_comb begin
        all_match = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            if (!hist_vld[i] || hist_addr[i] != ev_addr)
                all_match = 1'b0;
    end

    assign drop   = ev_valid & all_match;
    assign accept = ev_valid & ~all_match;
    assign newest = hist_vld[0] ? hist_addr[0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_vld     <= '0;
            hist_addr[0] <= '0;
        end else if (accept) begin
            hist_vld[0]  <= 1'b1;
            hist_addr[0] <= ev_addr;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_vld[g]  <= 1'b0;
                hist_addr[g] <= '0;
            end else if (accept) begin
                hist_vld[g]  <= hist_vld[g-1];
                hist_addr[g] <= hist_addr[g-1];
            end
        end
    end
endmodule

// File: rtl/sem_status_bits.sv
module sem_status_bits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[g] <= 1'b0;
            else if (set[g])
                status[g] <= 1'b1;
            else if (clr_wr && clr_mask[g])
                status[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/soc_err_monitor.sv
module soc_err_monitor
    import sem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ENC_W  = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_err,
    input  logic              mem_dbl,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [ENC_W-1:0]  mem_enc,
    input  logic              bus_timeout,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              ext_err
);
    localparam int HI_W = ENC_W - 32;
    localparam logic [ADDR_W-1:0] CHECK_BASE = ADDR_W'(3) << (ADDR_W - 2);

    logic               en_vote;
    logic               en_wr;
    logic               st_wr;
    logic               accept;
    logic               drop;
    logic [ADDR_W-1:0]  newest;
    logic [NUM_SRC-1:0] st_set;
    logic [NUM_SRC-1:0] status;
    logic [ADDR_W-1:0]  fault_addr;
    logic [ADDR_W-1:0]  check_addr;
    logic [ADDR_W-1:0]  prev_addr;
    logic [ENC_W-1:0]   enc_word;
    sem_reg_e           rsel;

    assign rsel  = sem_reg_e'(reg_addr);
    assign en_wr = reg_wr && rsel == REG_ENABLE;
    assign st_wr = reg_wr && rsel == REG_STATUS;

    sem_tmr_enable u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (en_wr),
        .wr_val (reg_wdata[0]),
        .vote   (en_vote)
    );

    sem_upset_filter #(.ADDR_W(ADDR_W), .DEPTH(2)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (mem_err & en_vote),
        .ev_addr  (mem_addr),
        .accept   (accept),
        .drop     (drop),
        .newest   (newest)
    );

    always_comb begin
        st_set             = '0;
        st_set[ST_TIMEOUT] = bus_timeout;
        st_set[ST_SINGLE]  = accept & ~mem_dbl;
        st_set[ST_DOUBLE]  = accept & mem_dbl;
    end

    sem_status_bits #(.N(NUM_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set      (st_set),
        .clr_wr   (st_wr),
        .clr_mask (reg_wdata[NUM_SRC-1:0]),
        .status   (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_addr <= '0;
            check_addr <= '0;
            prev_addr  <= '0;
            enc_word   <= '0;
        end else if (accept) begin
            fault_addr <= mem_addr;
            check_addr <= (mem_addr >> 2) + CHECK_BASE;
            prev_addr  <= newest;
            enc_word   <= mem_enc;
        end
    end

    assign ext_err = |status;

    always_comb begin
        reg_rdata = '0;
        case (rsel)
            REG_STATUS:     reg_rdata[NUM_SRC-1:0] = status;
            REG_ENABLE:     reg_rdata[0]           = en_vote;
            REG_FAULT_ADDR: reg_rdata[ADDR_W-1:0]  = fault_addr;
            REG_CHECK_ADDR: reg_rdata[ADDR_W-1:0]  = check_addr;
            REG_WORD_LO:    reg_rdata              = enc_word[31:0];
            REG_WORD_HI:    reg_rdata[HI_W-1:0]    = enc_word[ENC_W-1:32];
            REG_PREV_ADDR:  reg_rdata[ADDR_W-1:0]  = prev_addr;
            default:        reg_rdata              = '0;
        endcase
    end
endmodule

// File: rtl/sem_monitor_checker.sv
module sem_monitor_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_err,
    input logic              bus_timeout,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              en_vote,
    input logic              accept,
    input logic              drop,
    input logic [ADDR_W-1:0] newest,
    input logic [ADDR_W-1:0] fault_addr,
    input logic [2:0]        status,
    input logic              ext_err
);
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !ext_err); // R1

    AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (rst)
        accept |=> ext_err); // R2

    AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        bus_timeout |=> status[0]); // R5

    AST_MASKED_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mem_err && !en_vote) |=> $stable(fault_addr)); // R4

    AST_DROP_HOLDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
        drop |=> ($stable(newest) && $stable(fault_addr))); // R8

    AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd1) |=> (en_vote == $past(reg_wdata[0]))); // R9
endmodule

bind soc_err_monitor sem_monitor_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_err     (mem_err),
    .bus_timeout (bus_timeout),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .en_vote     (en_vote),
    .accept      (accept),
    .drop        (drop),
    .newest      (newest),
    .fault_addr  (fault_addr),
    .status      (status),
    .ext_err     (ext_err)
);

// File: tb/soc_err_monitor_test.sv
module soc_err_monitor_test;
    localparam int AW = 6;
    localparam int EW = 39;
    localparam int DATA_TOP = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_err = 1'b0;
    logic          mem_dbl = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [EW-1:0] mem_enc = '0;
    logic          bus_timeout = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ext_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    soc_err_monitor #(.ADDR_W(AW), .ENC_W(EW)) uut (
        .clk(clk), .rst(rst), .mem_err(mem_err), .mem_dbl(mem_dbl),
        .mem_addr(mem_addr), .mem_enc(mem_enc), .bus_timeout(bus_timeout),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_err(ext_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic mem_event(input logic [AW-1:0] a, input logic [EW-1:0] e, input logic dbl);
        @(negedge clk);
        mem_err = 1'b1; mem_addr = a; mem_enc = e; mem_dbl = dbl;
        @(negedge clk);
        mem_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [EW-1:0] pattern(input int a);
        return {7'(a * 3 + 1), 32'(a * 32'h9E3779B1)};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int last;
        do_reset();

        // R1 reset state
        for (int r = 0; r < 7; r++) begin
            rd(3'(r), v);
            check("R1 reg after reset", v, 32'd0);
        end
        check("R1 ext_err after reset", {31'd0, ext_err}, 32'd0);

        // R4 memory error masked while disabled
        mem_event(6'd5, pattern(5), 1'b0);
        rd(3'd0, v); check("R4 status masked", v, 32'd0);
        check("R4 ext_err masked", {31'd0, ext_err}, 32'd0);
        rd(3'd2, v); check("R4 no capture", v, 32'd0);

        // R5 timeout while disabled, R2 ext_err
        @(negedge clk); bus_timeout = 1'b1;
        @(negedge clk); bus_timeout = 1'b0;
        rd(3'd0, v); check("R5 timeout bit0", v, 32'd1);
        check("R2 ext_err on timeout", {31'd0, ext_err}, 32'd1);
        // R3 clear
        wr(3'd0, 32'h7);
        rd(3'd0, v); check("R3 w1c clears", v, 32'd0);
        check("R3 ext_err low after clear", {31'd0, ext_err}, 32'd0);
        // R3 set wins over clear
        @(negedge clk);
        bus_timeout = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
        @(negedge clk);
        bus_timeout = 1'b0; reg_wr = 1'b0;
        rd(3'd0, v); check("R3 set wins", v, 32'd1);
        wr(3'd0, 32'h1);

        // R9 enable write/read
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R9 enable reads 1", v, 32'd1);
        wr(3'd1, 32'hFFFF_FFFE);
        rd(3'd1, v); check("R9 enable uses bit0", v, 32'd0);
        wr(3'd1, 32'h1);

        // R4: masked event left history empty, R7 prev zero
        mem_event(6'd9, pattern(9), 1'b0);
        rd(3'd6, v); check("R4 R7 history untouched by masked", v, 32'd0);
        wr(3'd0, 32'h7);
        last = 9;

        // Sweep of the data region: R2 R6 R7 R11
        for (int a = 0; a < DATA_TOP; a++) begin
            logic dbl;
            logic [EW-1:0] e;
            dbl = a[0];
            e = pattern(a);
            mem_event(6'(a), e, dbl);
            rd(3'd0, v); check("R11 R2 status kind", v, dbl ? 32'd4 : 32'd2);
            check("R2 ext_err", {31'd0, ext_err}, 32'd1);
            rd(3'd2, v); check("R6 fault addr", v, 32'(a));
            rd(3'd3, v); check("R6 check addr", v, 32'(a / 4 + DATA_TOP));
            rd(3'd4, v); check("R6 word lo", v, e[31:0]);
            rd(3'd5, v); check("R6 word hi", v, {25'd0, e[38:32]});
            rd(3'd6, v); check("R7 prev addr", v, 32'(last));
            last = a;
            wr(3'd0, 32'h7);
        end

        // R8 stuck bit
        mem_event(6'd20, pattern(20), 1'b0);
        rd(3'd6, v); check("R7 prev before repeat", v, 32'(last));
        wr(3'd0, 32'h7);
        mem_event(6'd20, pattern(20), 1'b0);
        rd(3'd0, v); check("R8 second repeat accepted", v, 32'd2);
        rd(3'd6, v); check("R7 prev is repeat addr", v, 32'd20);
        wr(3'd0, 32'h7);
        mem_event(6'd20, pattern(33), 1'b1);
        rd(3'd0, v); check("R8 third repeat dropped", v, 32'd0);
        check("R8 no ext_err on drop", {31'd0, ext_err}, 32'd0);
        rd(3'd4, v); check("R8 capture unchanged", v, pattern(20) >> 0 & 39'hFFFFFFFF);
        mem_event(6'd21, pattern(21), 1'b0);
        rd(3'd6, v); check("R8 history unchanged by drop", v, 32'd20);
        wr(3'd0, 32'h7);

        // R10 first errors after reset not filtered
        do_reset();
        wr(3'd1, 32'h1);
        mem_event(6'd0, pattern(0), 1'b1);
        rd(3'd0, v); check("R10 first addr0 accepted", v, 32'd4);
        wr(3'd0, 32'h7);
        mem_event(6'd0, pattern(0), 1'b1);
        rd(3'd0, v); check("R10 second addr0 accepted", v, 32'd4);
        wr(3'd0, 32'h7);
        mem_event(6'd0, pattern(0), 1'b1);
        rd(3'd0, v); check("R8 third addr0 dropped", v, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule